// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Register

This block is the arithmetic core of a multiply-accumulate unit. Each cycle it multiplies two signed operands and either loads the product into a signed accumulator register or adds the product to it. A clear request zeroes the register instead. Two mode inputs shape the arithmetic. The fractional input treats both operands as signed fractions, which doubles the product. The saturation input decides what happens when a result goes out of range: the result is either clamped to the nearest representable extreme, or it wraps around and a sticky overflow flag is raised.

An overflow of the addition is recognised only when the two addends carry the same sign and the sum carries the opposite sign. When the addends have different signs, the sum can never leave the range. In fractional mode, the product of the most negative operand with itself cannot be represented after doubling. The same clamp-or-flag rule governs that case. Results are registered and appear on the outputs one clock after the request. The default widths are 16-bit operands and a 32-bit accumulator.

Top module: `mac_accum`

## Requirements
- R1: After a synchronous reset, `acc_out` is 0 and `ovf_flag` is 0.
- R2: When `clr` is high at a clock edge, `acc_out` becomes 0 and `ovf_flag` becomes 0 after that edge. This holds whatever `op_valid`, `load` and the modes are.
- R3: With `op_valid` and `load` high and `frac_en` low, `acc_out` becomes the signed product `op_a*op_b`, sign-extended to ACC_W bits.
- R4: With `op_valid` high and `load` low, `acc_out` becomes the previous accumulator value plus the product.
- R5: Every update appears one clock after the request. With `op_valid` low and `clr` low, `acc_out` and `ovf_flag` keep their values, whatever `load`, the operands and the modes are.
- R6: With `frac_en` high, the product used in a load or an add is twice the signed integer product.
- R7: With `sat_en` high, adding two non-negative values whose true sum exceeds 2^(ACC_W-1)-1 leaves that maximum positive value (0x7FFFFFFF for the default width).
- R8: With `sat_en` high, adding two negative values whose true sum is below -2^(ACC_W-1) leaves that most negative value (0x80000000 for the default width).
- R9: An add whose two addends differ in sign never clamps and never sets `ovf_flag`. The result is the exact sum.
- R10: With `sat_en` low, an out-of-range sum wraps modulo 2^ACC_W and sets `ovf_flag`.
- R11: Once set, `ovf_flag` stays at 1 until `clr` or reset, whatever the later operations are.
- R12: In fractional mode with ACC_W equal to 2*OP_W, a doubled product that is out of range behaves as follows. With `sat_en` high it is clamped before use. With `sat_en` low it wraps to the most negative value and sets `ovf_flag`.
- R13: While `sat_en` is high, no operation sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sat_en | input | 1 | 1: clamp out-of-range results; 0: wrap and flag |
| frac_en | input | 1 | 1: operands are signed fractions (product doubled) |
| clr | input | 1 | Zero accumulator and flag; highest priority |
| op_valid | input | 1 | Operands are valid this cycle |
| load | input | 1 | With op_valid: replace accumulator instead of adding |
| op_a | input | OP_W | Signed multiplicand |
| op_b | input | OP_W | Signed multiplier |
| acc_out | output | ACC_W | Registered signed accumulator value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The clamp properties assume that the product seen by the adder already lies within the accumulator range. They also assume that a clear outranks every other request, so each clamp property is gated on `clr` being low and an add being requested. The stimulus drives every operand pair of a 4-bit by 4-bit, 8-bit-accumulator configuration under all four mode combinations, with a clear before each trial. Clears therefore land mid-stream while `op_valid` and `load` are high. Both mixed-sign and same-sign adds follow each load. Separate runs of held cycles toggle `load`, the operands and the modes while `op_valid` stays low, so the hold property is exercised with busy inputs.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_ADD   = 2'd3
  } mac_act_e;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic     clr,
  input  logic     op_valid,
  input  logic     load,
  output mac_act_e act
);

  // Clear outranks every operand request (R2); without valid operands, hold (R5).
  always_comb begin
    if (clr)           act = ACT_CLEAR;
    else if (!op_valid) act = ACT_HOLD;
    else if (load)     act = ACT_LOAD;
    else               act = ACT_ADD;
  end

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             frac_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] prod,
  output logic             prod_ovf
);

  localparam int PW = 2 * OP_W;
  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PW-1:0] raw;
  logic [ACC_W-1:0]     ext;
  logic [ACC_W-1:0]     dbl;

  assign raw = $signed(op_a) * $signed(op_b);

  generate
    if (ACC_W > PW) begin : g_widen
      assign ext = {{(ACC_W-PW){raw[PW-1]}}, raw};
    end else begin : g_exact
      assign ext = raw[ACC_W-1:0];
    end
  endgenerate

  assign dbl = {ext[ACC_W-2:0], 1'b0};

  // Doubling overflows only if the two top bits of the integer product disagree (R12).
  always_comb begin
    prod_ovf = frac_en && (ext[ACC_W-1] != ext[ACC_W-2]);
    if (!frac_en)
      prod = ext;
    else if (prod_ovf && sat_en)
      prod = ext[ACC_W-1] ? MINV : MAXV;
    else
      prod = dbl;
  end

endmodule

// File: rtl/mac_adder.sv
module mac_adder #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] addend,
  input  logic             sat_en,
  output logic [ACC_W-1:0] result,
  output logic             add_ovf
);

  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] sum;

  assign sum = acc + addend;

  // Same-sign addends with an opposite-sign sum is the only overflow (R9).
  always_comb begin
    add_ovf = (acc[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
    if (add_ovf && sat_en)
      result = acc[ACC_W-1] ? MINV : MAXV;
    else
      result = sum;
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sat_en,
  input  logic             frac_en,
  input  logic             clr,
  input  logic             op_valid,
  input  logic             load,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_flag
);

  mac_act_e         act;
  logic [ACC_W-1:0] prod_val;
  logic             prod_ovf;
  logic [ACC_W-1:0] add_res;
  logic             add_ovf;
  logic [ACC_W-1:0] acc_q;
  logic             flag_q;

  mac_ctrl u_ctrl (
    .clr      (clr),
    .op_valid (op_valid),
    .load     (load),
    .act      (act)
  );

  mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .op_a     (op_a),
    .op_b     (op_b),
    .frac_en  (frac_en),
    .sat_en   (sat_en),
    .prod     (prod_val),
    .prod_ovf (prod_ovf)
  );

  mac_adder #(.ACC_W(ACC_W)) u_add (
    .acc     (acc_q),
    .addend  (prod_val),
    .sat_en  (sat_en),
    .result  (add_res),
    .add_ovf (add_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_CLEAR: begin
          acc_q  <= '0;
          flag_q <= 1'b0;
        end
        ACT_LOAD: begin
          acc_q  <= prod_val;
          flag_q <= flag_q | (prod_ovf & ~sat_en);
        end
        ACT_ADD: begin
          acc_q  <= add_res;
          flag_q <= flag_q | ((prod_ovf | add_ovf) & ~sat_en);
        end
        default: begin
          acc_q  <= acc_q;
          flag_q <= flag_q;
        end
      endcase
    end
  end

  assign acc_out  = acc_q;
  assign ovf_flag = flag_q;

endmodule

// File: rtl/mac_accum_chk.sv
module mac_accum_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             op_valid,
  input logic             load,
  input logic             sat_en,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_flag,
  input logic [ACC_W-1:0] prod,
  input logic             prod_ovf
);

  localparam int MSB = ACC_W - 1;

  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_out == '0) && !ovf_flag);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr && !op_valid) |=> ($stable(acc_out) && $stable(ovf_flag)));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr) |=> ovf_flag);

  a_r13_sat_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (!clr && sat_en && !ovf_flag) |=> !ovf_flag);

  a_r7_pos_clamp: assert property (@(posedge clk) disable iff (rst)
    (!clr && op_valid && !load && sat_en && !acc_out[MSB] && !prod[MSB]) |=> !acc_out[MSB]);

  a_r8_neg_clamp: assert property (@(posedge clk) disable iff (rst)
    (!clr && op_valid && !load && sat_en && acc_out[MSB] && prod[MSB]) |=> acc_out[MSB]);

  a_r9_mixed_signs: assert property (@(posedge clk) disable iff (rst)
    (!clr && op_valid && !load && !sat_en && !prod_ovf && !ovf_flag
     && (acc_out[MSB] != prod[MSB])) |=> !ovf_flag);

endmodule

bind mac_accum mac_accum_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .op_valid (op_valid),
  .load     (load),
  .sat_en   (sat_en),
  .acc_out  (acc_out),
  .ovf_flag (ovf_flag),
  .prod     (prod_val),
  .prod_ovf (prod_ovf)
);

// File: tb/mac_accum_test.sv
module mac_accum_test;

  localparam int OW   = 4;
  localparam int AW   = 8;
  localparam int MAXV = (1 << (AW-1)) - 1;
  localparam int MINV = -(1 << (AW-1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sat_en = 1'b0, frac_en = 1'b0, clr = 1'b0, op_valid = 1'b0, load = 1'b0;
  logic [OW-1:0] op_a = '0, op_b = '0;
  logic [AW-1:0] acc_out;
  logic          ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  int exp_acc = 0;
  bit exp_flag = 1'b0;

  always #10 clk = ~clk;

  mac_accum #(.OP_W(OW), .ACC_W(AW)) uut (
    .clk(clk), .rst(rst), .sat_en(sat_en), .frac_en(frac_en), .clr(clr),
    .op_valid(op_valid), .load(load), .op_a(op_a), .op_b(op_b),
    .acc_out(acc_out), .ovf_flag(ovf_flag)
  );

  function automatic int wrapw(int x);
    logic [AW-1:0] t;
    t = x[AW-1:0];
    return int'($signed(t));
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (int'($signed(acc_out)) != exp_acc || ovf_flag !== exp_flag) begin
      n_fail++;
      $display("FAIL %s: acc=%0d flag=%0b expected acc=%0d flag=%0b",
               tag, $signed(acc_out), ovf_flag, exp_acc, exp_flag);
    end
  endtask

  // Compute the expected result, apply one cycle of stimulus, check at the next falling edge.
  task automatic op(bit c, bit v, bit l, bit s, bit f, int a, int b);
    int    p, t;
    bit    povf, sovf;
    string tag;
    p = a * b;
    if (f) p = p * 2;
    povf = (p > MAXV) || (p < MINV);
    if (povf) p = s ? ((p > 0) ? MAXV : MINV) : wrapw(p);
    if (c) begin
      exp_acc = 0; exp_flag = 1'b0; tag = "R2";
    end else if (!v) begin
      tag = "R5";
    end else if (l) begin
      exp_acc = p;
      if (povf && !s) exp_flag = 1'b1;
      tag = povf ? "R12" : (f ? "R6" : "R3");
    end else begin
      t = exp_acc + p;
      sovf = (t > MAXV) || (t < MINV);
      if (sovf) tag = s ? ((t > 0) ? "R7" : "R8") : "R10";
      else if ((exp_acc < 0) != (p < 0)) tag = "R9";
      else tag = s ? "R13" : "R4";
      if (sovf) t = s ? ((t > 0) ? MAXV : MINV) : wrapw(t);
      if ((povf || sovf) && !s) exp_flag = 1'b1;
      exp_acc = t;
    end
    clr = c; op_valid = v; load = l; sat_en = s; frac_en = f;
    op_a = a[OW-1:0]; op_b = b[OW-1:0];
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1");
    // R5: latency and hold with busy inputs
    op(0, 1, 1, 0, 0, 3, 3);
    for (int k = 0; k < 4; k++) op(0, 0, k[0], k[1], k[0], 7 - k, -8 + k);
    // R11: flag raised by wrap stays through clean adds, cleared only by clr
    op(0, 1, 1, 0, 1, -8, -8);
    op(0, 1, 0, 0, 0, 1, 1);
    op(0, 1, 0, 1, 0, 1, -1);
    op(0, 0, 0, 0, 0, 0, 0);
    op(1, 1, 1, 1, 1, 7, 7);
    // R3,R4,R6..R10,R12,R13: exhaustive operand sweep under every mode pair
    for (int m = 0; m < 4; m++) begin
      for (int a = -8; a < 8; a++) begin
        for (int b = -8; b < 8; b++) begin
          op(1, 1, 1, m[0], m[1], a, b);
          op(0, 1, 1, m[0], m[1], a, b);
          op(0, 1, 0, m[0], m[1], a, b);
          op(0, 1, 0, m[0], m[1], b, -a - 1);
          op(0, 1, 0, m[0], m[1], a, b);
        end
      end
    end
    // R1: reset mid-stream
    op(0, 1, 1, 0, 1, -8, -8);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_acc = 0; exp_flag = 1'b0;
    op_valid = 1'b0; clr = 1'b0;
    @(negedge clk);
    check("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule